// File: doc/BRIEF.md
# Receive Frame Synchronizer

This block sits behind the 8B/10B decoder of a serial radio-link receiver and tracks whether the incoming character stream is aligned to the link's hyperframe structure. It takes one decoded character per strobe, with a comma flag, the line-code-violation count of the cycle and a loss-of-signal input. It walks a four-state machine: loss of signal, acquisition, synchronization, and hyperframe-synchronized. In acquisition it counts commas toward a required run. Once synchronized, it checks that commas keep landing exactly on hyperframe boundaries.

The outputs are the state, the comma progress count, a hyperframe-lock flag and a basic-frame-lock flag. The basic-frame flag rises one hyperframe after hyperframe lock, once downstream frame-number counters have had a boundary to load from. A frequency monitor compares recovered-clock ticks against local cycles over a fixed window. All of these fields are also packed into a 12-bit status word for debug capture.

Top module: `rx_frame_sync`

## Requirements
- R1: After reset, state_o is 00 (loss of signal), comma_cnt_o is 0, both lock flags and freq_alarm_o are 0, and status_o is 0.
- R2: In the loss state with los_i low, a cycle with char_valid_i high moves the machine to acquisition (01) with a comma count of 0.
- R3: In acquisition, each valid comma raises the comma count by one. Valid non-comma characters leave it unchanged. The COMMA_RUN-th comma (default 5) moves the machine to synchronization (10), and comma_cnt_o then holds COMMA_RUN.
- R4: In acquisition, a nonzero lcv_cnt_i clears the comma count and keeps the state at 01, even when a comma arrives in the same cycle.
- R5: In synchronization, a comma arriving as exactly the HF_LEN-th valid character after the last counted comma (default 16) moves the machine to 11 and sets hfn_lock_o, while bfn_lock_o stays 0.
- R6: In state 11, the next comma at the following hyperframe boundary sets bfn_lock_o. bfn_lock_o is never 1 while hfn_lock_o is 0.
- R7: In states 10 or 11, a comma away from the boundary, or a non-comma character on the boundary, returns the machine to 01 with the count and both flags cleared.
- R8: los_i high forces state 00, count 0 and both flags 0 on the next cycle, from any state, and holds them there while it stays high.
- R9: status_o packs bit 11 = los_i and bits 10:8 = lcv_cnt_i, both as sampled at the previous edge. Bit 7 is hfn_lock_o, bit 6 is bfn_lock_o, bit 5 is freq_alarm_o, bits 4:2 are comma_cnt_o and bits 1:0 are state_o.
- R10: Over each window of FREQ_WIN local cycles (default 64), freq_alarm_o is set for the next window when more than FREQ_TOL (default 4) rec_tick_i pulses are missing, and cleared otherwise. It changes only at window ends.
- R11: Cycles with char_valid_i low have no effect on state, count or flags, whatever comma_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Decoded character present this cycle |
| comma_i | input | 1 | Character is a K28.5 comma |
| lcv_cnt_i | input | 3 | Line-code violations seen this cycle |
| los_i | input | 1 | Loss of signal, active high |
| rec_tick_i | input | 1 | One pulse per recovered-clock cycle, in the local domain |
| state_o | output | 2 | 00 loss, 01 acquisition, 10 sync, 11 hyperframe sync |
| comma_cnt_o | output | 3 | Commas counted toward the required run |
| hfn_lock_o | output | 1 | Hyperframe synchronization achieved |
| bfn_lock_o | output | 1 | Basic-frame numbers initialized |
| freq_alarm_o | output | 1 | Recovered clock deviates beyond tolerance |
| status_o | output | 12 | Packed status word |

## Verification
The hardest situation to reach is the boundary test in synchronization: the exact character on which a comma becomes valid, and the off-by-one neighbours on each side. To reach it, the stimulus re-acquires the link through a loss pulse before each trial. It then places the next comma at every offset from 1 to HF_LEN+1 characters after the entry comma, and expects promotion only at offset HF_LEN. The frequency alarm threshold is swept the same way, by dropping 0 to 8 recovered ticks per window across several whole windows.

// File: rtl/rx_fsync_pkg.sv
package rx_fsync_pkg;
  typedef enum logic [1:0] {
    ST_LOS   = 2'b00,
    ST_XACQ  = 2'b01,
    ST_XSYNC = 2'b10,
    ST_HSYNC = 2'b11
  } fsync_state_e;

  typedef struct packed {
    logic         los;
    logic [2:0]   lcv;
    logic         hfn;
    logic         bfn;
    logic         alarm;
    logic [2:0]   cnt;
    fsync_state_e state;
  } fsync_status_t;
endpackage

// File: rtl/rx_fsync_pos.sv
module rx_fsync_pos #(
  parameter int HF_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  output logic at_bnd_o
);
  localparam int POS_W = (HF_LEN > 1) ? $clog2(HF_LEN) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(HF_LEN - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (clr_i)    pos_q <= '0;
    else if (valid_i)  pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  end

  assign at_bnd_o = (pos_q == POS_LAST);

  assert_pos_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_LAST);
  assert_pos_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(pos_q));
endmodule

// File: rtl/rx_fsync_fsm.sv
module rx_fsync_fsm
  import rx_fsync_pkg::*;
#(
  parameter int COMMA_RUN = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         comma_i,
  input  logic         lcv_hit_i,
  input  logic         los_i,
  input  logic         at_bnd_i,
  output fsync_state_e state_o,
  output logic [2:0]   cnt_o,
  output logic         hfn_o,
  output logic         bfn_o,
  output logic         pos_clr_o
);
  localparam logic [2:0] RUN_LAST = 3'(COMMA_RUN - 1);
  localparam logic [2:0] RUN_FULL = 3'(COMMA_RUN);

  fsync_state_e state_q;
  logic [2:0]   cnt_q;
  logic         hfn_q, bfn_q;
  logic         misplaced;

  // comma off the boundary, or boundary without comma
  assign misplaced = valid_i && (comma_i != at_bnd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOS;
      cnt_q   <= '0;
      hfn_q   <= 1'b0;
      bfn_q   <= 1'b0;
    end else if (los_i) begin
      state_q <= ST_LOS;
      cnt_q   <= '0;
      hfn_q   <= 1'b0;
      bfn_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LOS: begin
          if (valid_i) begin
            state_q <= ST_XACQ;
            cnt_q   <= '0;
          end
        end
        ST_XACQ: begin
          if (lcv_hit_i) begin
            cnt_q <= '0;
          end else if (valid_i && comma_i) begin
            if (cnt_q == RUN_LAST) begin
              state_q <= ST_XSYNC;
              cnt_q   <= RUN_FULL;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_XSYNC: begin
          if (misplaced) begin
            state_q <= ST_XACQ;
            cnt_q   <= '0;
          end else if (valid_i && comma_i) begin
            state_q <= ST_HSYNC;
            hfn_q   <= 1'b1;
          end
        end
        default: begin
          if (misplaced) begin
            state_q <= ST_XACQ;
            cnt_q   <= '0;
            hfn_q   <= 1'b0;
            bfn_q   <= 1'b0;
          end else if (valid_i && comma_i) begin
            bfn_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign hfn_o     = hfn_q;
  assign bfn_o     = bfn_q;
  assign pos_clr_o = (state_q == ST_LOS) || (state_q == ST_XACQ);

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RUN_FULL);
  assert_sync_from_acq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XSYNC && $past(state_q) != ST_XSYNC) |-> $past(state_q) == ST_XACQ);
  assert_hfn_in_hsync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hfn_q |-> state_q == ST_HSYNC);
  assert_bfn_needs_hfn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bfn_q |-> hfn_q);
  assert_los_forces_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |=> (state_q == ST_LOS && cnt_q == '0 && !hfn_q && !bfn_q));
  assert_idle_char_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !los_i && !lcv_hit_i) |=> ($stable(state_q) && $stable(cnt_q)));
endmodule

// File: rtl/rx_fsync_freq.sv
module rx_fsync_freq #(
  parameter int FREQ_WIN = 64,
  parameter int FREQ_TOL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic alarm_o
);
  localparam int WIN_W = (FREQ_WIN > 1) ? $clog2(FREQ_WIN) : 1;
  localparam int TCK_W = $clog2(FREQ_WIN + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(FREQ_WIN - 1);

  logic [WIN_W-1:0] win_q;
  logic [TCK_W-1:0] tck_q;
  logic [TCK_W-1:0] tck_total;
  logic             win_end;
  logic             alarm_q;

  assign win_end   = (win_q == WIN_LAST);
  assign tck_total = tck_q + TCK_W'(tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      tck_q   <= '0;
      alarm_q <= 1'b0;
    end else if (win_end) begin
      win_q   <= '0;
      tck_q   <= '0;
      alarm_q <= (FREQ_WIN - int'(tck_total)) > FREQ_TOL;
    end else begin
      win_q <= win_q + 1'b1;
      tck_q <= tck_total;
    end
  end

  assign alarm_o = alarm_q;

  assert_alarm_at_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(alarm_q));
  assert_tick_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tck_q) <= FREQ_WIN);
endmodule

// File: rtl/rx_frame_sync.sv
module rx_frame_sync
  import rx_fsync_pkg::*;
#(
  parameter int COMMA_RUN = 5,
  parameter int HF_LEN    = 16,
  parameter int FREQ_WIN  = 64,
  parameter int FREQ_TOL  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        char_valid_i,
  input  logic        comma_i,
  input  logic [2:0]  lcv_cnt_i,
  input  logic        los_i,
  input  logic        rec_tick_i,
  output logic [1:0]  state_o,
  output logic [2:0]  comma_cnt_o,
  output logic        hfn_lock_o,
  output logic        bfn_lock_o,
  output logic        freq_alarm_o,
  output logic [11:0] status_o
);
  fsync_state_e  state;
  logic [2:0]    cnt;
  logic          hfn, bfn, alarm, pos_clr, at_bnd;
  logic          los_q;
  logic [2:0]    lcv_q;
  fsync_status_t stat;

  rx_fsync_pos #(.HF_LEN(HF_LEN)) pos_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (pos_clr),
    .valid_i  (char_valid_i),
    .at_bnd_o (at_bnd)
  );

  rx_fsync_fsm #(.COMMA_RUN(COMMA_RUN)) fsm_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (char_valid_i),
    .comma_i   (comma_i),
    .lcv_hit_i (lcv_cnt_i != 3'd0),
    .los_i     (los_i),
    .at_bnd_i  (at_bnd),
    .state_o   (state),
    .cnt_o     (cnt),
    .hfn_o     (hfn),
    .bfn_o     (bfn),
    .pos_clr_o (pos_clr)
  );

  rx_fsync_freq #(.FREQ_WIN(FREQ_WIN), .FREQ_TOL(FREQ_TOL)) freq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (rec_tick_i),
    .alarm_o (alarm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_q <= 1'b0;
      lcv_q <= '0;
    end else begin
      los_q <= los_i;
      lcv_q <= lcv_cnt_i;
    end
  end

  always_comb begin
    stat.los   = los_q;
    stat.lcv   = lcv_q;
    stat.hfn   = hfn;
    stat.bfn   = bfn;
    stat.alarm = alarm;
    stat.cnt   = cnt;
    stat.state = state;
  end

  assign status_o     = stat;
  assign state_o      = state;
  assign comma_cnt_o  = cnt;
  assign hfn_lock_o   = hfn;
  assign bfn_lock_o   = bfn;
  assign freq_alarm_o = alarm;

  assert_los_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |=> status_o[11] && status_o[1:0] == 2'b00);
  assert_lcv_field_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[10:8] == $past(lcv_cnt_i));
endmodule

// File: tb/rx_frame_sync_tb_top.sv
module rx_frame_sync_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HF  = 16;
  localparam int RUN = 5;
  localparam int WIN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, comma = 1'b0, los = 1'b0, tick = 1'b1;
  logic [2:0]  lcv = 3'd0;
  logic [1:0]  state;
  logic [2:0]  cnt;
  logic        hfn, bfn, alarm;
  logic [11:0] status;
  logic        last_los = 1'b0;
  logic [2:0]  last_lcv = 3'd0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_sync dut_i (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(valid), .comma_i(comma),
    .lcv_cnt_i(lcv), .los_i(los), .rec_tick_i(tick), .state_o(state),
    .comma_cnt_o(cnt), .hfn_lock_o(hfn), .bfn_lock_o(bfn),
    .freq_alarm_o(alarm), .status_o(status)
  );

  task automatic cyc(input logic v, input logic c, input logic [2:0] l, input logic s);
    valid = v; comma = c; lcv = l; los = s;
    last_los = s; last_lcv = l;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] es, input logic [2:0] ec,
                     input logic eh, input logic eb);
    logic [11:0] ew;
    ew = {last_los, last_lcv, eh, eb, 1'b0, ec, es};
    n_run++;
    if (state !== es || cnt !== ec || hfn !== eh || bfn !== eb || status !== ew) begin
      n_fail++;
      $display("FAIL %s: state=%b cnt=%0d hfn=%b bfn=%b status=%h, expected state=%b cnt=%0d hfn=%b bfn=%b status=%h",
               req, state, cnt, hfn, bfn, status, es, ec, eh, eb, ew);
    end
  endtask

  // from any state: loss pulse, first char, then RUN commas -> sync
  task automatic acquire();
    cyc(0, 0, 0, 1);
    cyc(1, 0, 0, 0);
    for (int i = 0; i < RUN; i++) cyc(1, 1, 0, 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 2'b00, 3'd0, 0, 0);
    n_run++;
    if (alarm !== 1'b0) begin
      n_fail++; $display("FAIL R1 alarm: got %b expected 0", alarm);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R11: no valid strobe, comma line toggled -> still in loss state
    cyc(0, 1, 0, 0);
    chk("R11 idle in loss", 2'b00, 3'd0, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R2 loss to acq", 2'b01, 3'd0, 0, 0);

    // R3: count commas, fillers keep count, invalid cycles ignored
    cyc(1, 1, 0, 0); chk("R3 count 1", 2'b01, 3'd1, 0, 0);
    cyc(1, 0, 0, 0); chk("R3 filler keeps", 2'b01, 3'd1, 0, 0);
    cyc(0, 1, 0, 0); chk("R11 invalid comma", 2'b01, 3'd1, 0, 0);
    cyc(1, 1, 0, 0); chk("R3 count 2", 2'b01, 3'd2, 0, 0);
    cyc(1, 1, 0, 0); chk("R3 count 3", 2'b01, 3'd3, 0, 0);
    // R4: violation clears, even with a comma present
    cyc(1, 1, 3'd5, 0); chk("R4 lcv clears", 2'b01, 3'd0, 0, 0);
    cyc(0, 0, 3'd1, 0); chk("R4 lcv no char", 2'b01, 3'd0, 0, 0);
    for (int i = 1; i < RUN; i++) begin
      cyc(1, 1, 0, 0); chk("R3 recount", 2'b01, 3'(i), 0, 0);
    end
    cyc(1, 1, 0, 0); chk("R3 enter sync", 2'b10, 3'(RUN), 0, 0);

    // R5/R6: hyperframe then basic-frame lock
    for (int i = 0; i < HF - 1; i++) begin
      cyc(1, 0, 0, 0);
      if (i % 2 == 0) cyc(0, 1, 0, 0); // invalid cycles in between, R11
    end
    chk("R11 gaps in sync", 2'b10, 3'(RUN), 0, 0);
    cyc(1, 1, 0, 0); chk("R5 hfn lock", 2'b11, 3'(RUN), 1, 0);
    for (int i = 0; i < HF - 1; i++) cyc(1, 0, 0, 0);
    chk("R6 before bfn", 2'b11, 3'(RUN), 1, 0);
    cyc(1, 1, 0, 0); chk("R6 bfn lock", 2'b11, 3'(RUN), 1, 1);
    cyc(1, 0, 3'd7, 0); chk("R9 lcv field in lock", 2'b11, 3'(RUN), 1, 1);
    for (int i = 0; i < HF - 2; i++) cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0); chk("R6 lock holds", 2'b11, 3'(RUN), 1, 1);
    // R7: early comma in lock
    cyc(1, 0, 0, 0); cyc(1, 1, 0, 0);
    chk("R7 early comma in lock", 2'b01, 3'd0, 0, 0);

    // R7: missing comma on boundary in lock
    acquire();
    for (int i = 0; i < HF - 1; i++) cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0); chk("R5 relock", 2'b11, 3'(RUN), 1, 0);
    for (int i = 0; i < HF - 1; i++) cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0); chk("R7 missing comma", 2'b01, 3'd0, 0, 0);

    // R8: loss from lock, held while high
    acquire();
    for (int i = 0; i < HF - 1; i++) cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 3'd2, 1); chk("R8 loss from lock", 2'b00, 3'd0, 0, 0);
    cyc(1, 1, 0, 1); chk("R8 loss held", 2'b00, 3'd0, 0, 0);

    // boundary sweep: comma at offset m after sync entry
    for (int m = 1; m <= HF + 1; m++) begin
      acquire();
      chk("R3 sweep entry", 2'b10, 3'(RUN), 0, 0);
      for (int i = 0; i < m - 1; i++) cyc(1, 0, 0, 0);
      cyc(1, 1, 0, 0);
      if (m == HF)          chk("R5 sweep on boundary", 2'b11, 3'(RUN), 1, 0);
      else if (m == HF + 1) chk("R7 sweep late", 2'b01, 3'd1, 0, 0);
      else                  chk("R7 sweep early", 2'b01, 3'd0, 0, 0);
    end

    // R10: drop k ticks per window
    cyc(0, 0, 0, 0);
    for (int k = 0; k <= 8; k++) begin
      for (int c = 0; c < 3 * WIN; c++) begin
        tick = ((c % WIN) >= k);
        @(negedge clk);
      end
      n_run++;
      if (alarm !== (k > 4) || status[5] !== (k > 4)) begin
        n_fail++;
        $display("FAIL R10 k=%0d: alarm=%b status5=%b expected %b", k, alarm, status[5], (k > 4));
      end
    end
    tick = 1'b1;
    repeat (2 * WIN) @(negedge clk);
    n_run++;
    if (alarm !== 1'b0) begin
      n_fail++; $display("FAIL R10 clear: alarm=%b expected 0", alarm);
    end

    done = 1'b1;
    finish_run();
  end
endmodule